// File: doc/BRIEF.md
# Escaped Stream Frame Transmitter

This block turns a variable-length message held in a transmit buffer into a delimited word stream. The layer above writes the message into the buffer, presents its length and pulses a request. The block raises a frame-pending flag, sends a start delimiter and then the payload words in buffer order. It ends with a stop delimiter and drops the frame-pending flag when that stop delimiter goes out.

Payload words that collide with one of the four reserved values are escaped. In their place the block sends the escape word, followed by the original word XORed with a fixed key. XOR is its own inverse, so a receiver recovers the value with the same key. Each word is handed to the lower layer by raising a word-pending flag. The block issues nothing more until the lower layer pulses a take strobe to clear that flag. The buffer is read through a synchronous read port with one cycle of latency.

Top module: `esc_frame_tx`

## Requirements
- R1: After reset, `word_pend`, `frame_flag` and `busy` are 0 and `rd_addr` is 0.
- R2: A `frame_req` pulse while `frame_flag` is 0 sets `frame_flag`. Once no word is pending, the start delimiter (default 8'h7E) is issued, and `busy` rises in the same cycle.
- R3: A word is issued only while `word_pend` is 0. `word_pend` then stays 1 and `word_out` stays unchanged until a `word_take` pulse clears it.
- R4: Payload words that are not reserved are sent unchanged, in buffer order from address 0 up to length−1.
- R5: A payload word equal to a reserved value (start 8'h7E, stop 8'h7F, escape 8'h7D, key 8'h20) is sent as two words: the escape word, then the payload word XOR 8'h20.
- R6: After the last payload word the stop delimiter (default 8'h7F) is issued. `frame_flag` and `busy` both drop in that same cycle.
- R7: A length of 0 produces exactly two words: start delimiter, then stop delimiter.
- R8: `msg_len` is captured when the request is accepted. Later changes of `msg_len` and `frame_req` pulses while `frame_flag` is 1 have no effect on the current frame, and no further frame follows.
- R9: `rd_addr` advances only after a payload word has been fully issued, which for an escaped word means after its second word. It holds while a word is pending.
- R10: A frame of m payload words with k reserved words occupies m+k+2 words, so between m+2 and 2m+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_req | input | 1 | One-cycle request to send a frame |
| msg_len | input | LW | Payload length in words, captured with the request |
| rd_addr | output | LW | Transmit buffer read address |
| rd_data | input | W | Buffer word, valid one cycle after `rd_addr` |
| word_out | output | W | Word handed to the lower layer |
| word_pend | output | 1 | A word is waiting to be taken |
| word_take | input | 1 | Lower layer has sent the pending word |
| frame_flag | output | 1 | Frame requested and not yet completed |
| busy | output | 1 | Frame transmission in progress |

## Verification
A wrong state or address counter shows up as a wrong word at the port. The cost is one dropped, duplicated or unescaped word, or a word read from the wrong address. It appears at the very next take after the fault. Flag bookkeeping faults appear as `frame_flag` or `busy` still high when the stop delimiter is visible, or as a spurious second frame a few cycles later. The bench compares each word against a reference stream built from the buffer contents. It also checks for stability and for an unchanged address during random take delays.

// File: rtl/esc_frame_tx.sv
module esc_frame_tx #(
  parameter int W  = 8,
  parameter int LW = 8,
  parameter logic [W-1:0] SOF_WORD = 8'h7E,
  parameter logic [W-1:0] EOF_WORD = 8'h7F,
  parameter logic [W-1:0] ESC_WORD = 8'h7D,
  parameter logic [W-1:0] XOR_KEY  = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_req,
  input  logic [LW-1:0] msg_len,
  output logic [LW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output logic [W-1:0]  word_out,
  output logic          word_pend,
  input  logic          word_take,
  output logic          frame_flag,
  output logic          busy
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DATA, S_ENC, S_TAIL} st_t;

  st_t           st;
  logic [LW-1:0] len_q;
  logic [LW-1:0] idx;

  wire reserved = (rd_data == SOF_WORD) || (rd_data == EOF_WORD) ||
                  (rd_data == ESC_WORD) || (rd_data == XOR_KEY);
  wire last     = ({1'b0, idx} + 1'b1) == {1'b0, len_q};
  wire [LW-1:0] idx_nx = idx + 1'b1;

  assign rd_addr = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      len_q      <= '0;
      idx        <= '0;
      word_out   <= '0;
      word_pend  <= 1'b0;
      frame_flag <= 1'b0;
      busy       <= 1'b0;
    end else begin
      if (word_take) word_pend <= 1'b0;
      if (frame_req && !frame_flag) begin
        frame_flag <= 1'b1;
        len_q      <= msg_len;
      end
      case (st)
        S_IDLE: if (frame_flag && !word_pend) begin
          word_out  <= SOF_WORD;
          word_pend <= 1'b1;
          busy      <= 1'b1;
          idx       <= '0;
          st        <= (len_q == '0) ? S_TAIL : S_FETCH;
        end
        S_FETCH: st <= S_DATA;
        S_DATA: if (!word_pend) begin
          word_pend <= 1'b1;
          if (reserved) begin
            word_out <= ESC_WORD;
            st       <= S_ENC;
          end else begin
            word_out <= rd_data;
            idx      <= idx_nx;
            st       <= last ? S_TAIL : S_FETCH;
          end
        end
        S_ENC: if (!word_pend) begin
          word_out  <= rd_data ^ XOR_KEY;
          word_pend <= 1'b1;
          idx       <= idx_nx;
          st        <= last ? S_TAIL : S_FETCH;
        end
        S_TAIL: if (!word_pend) begin
          word_out   <= EOF_WORD;
          word_pend  <= 1'b1;
          busy       <= 1'b0;
          frame_flag <= 1'b0;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/esc_frame_tx_chk.sv
module esc_frame_tx_chk #(
  parameter int W  = 8,
  parameter int LW = 8,
  parameter logic [W-1:0] SOF_WORD = 8'h7E,
  parameter logic [W-1:0] EOF_WORD = 8'h7F,
  parameter logic [W-1:0] ESC_WORD = 8'h7D,
  parameter logic [W-1:0] XOR_KEY  = 8'h20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] rd_addr,
  input logic [W-1:0]  word_out,
  input logic          word_pend,
  input logic          word_take,
  input logic          frame_flag,
  input logic          busy
);

  logic esc_seen;
  wire  out_res = (word_out == SOF_WORD) || (word_out == EOF_WORD) ||
                  (word_out == ESC_WORD) || (word_out == XOR_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) esc_seen <= 1'b0;
    else if ($rose(word_pend)) esc_seen <= busy && (word_out == ESC_WORD);
  end

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_pend && !word_take |=> word_pend && $stable(word_out)); // R3
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> frame_flag); // R2
  AST_SOF_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> word_pend && word_out == SOF_WORD); // R2
  AST_EOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_flag) |-> word_pend && word_out == EOF_WORD && !busy); // R6
  AST_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_pend) && esc_seen |-> !out_res); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    word_pend && !word_take |=> $stable(rd_addr)); // R9

endmodule

bind esc_frame_tx esc_frame_tx_chk #(
  .W(W), .LW(LW), .SOF_WORD(SOF_WORD), .EOF_WORD(EOF_WORD),
  .ESC_WORD(ESC_WORD), .XOR_KEY(XOR_KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .word_out(word_out),
  .word_pend(word_pend), .word_take(word_take),
  .frame_flag(frame_flag), .busy(busy)
);

// File: tb/esc_frame_tx_tb.sv
module esc_frame_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_req = 1'b0;
  logic [7:0] msg_len = '0;
  logic [7:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [7:0] word_out;
  logic       word_pend;
  logic       word_take = 1'b0;
  logic       frame_flag;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] exp_w [520];
  int exp_n;

  always #2.5 clk = ~clk;

  esc_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .msg_len(msg_len),
    .rd_addr(rd_addr), .rd_data(rd_data), .word_out(word_out),
    .word_pend(word_pend), .word_take(word_take),
    .frame_flag(frame_flag), .busy(busy));

  always_ff @(posedge clk) rd_data <= mem[rd_addr];

  function automatic bit is_res(logic [7:0] v);
    return v == 8'h7E || v == 8'h7F || v == 8'h7D || v == 8'h20;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build_exp(int len);
    exp_n = 0;
    exp_w[exp_n++] = 8'h7E;
    for (int i = 0; i < len; i++) begin
      if (is_res(mem[i])) begin
        exp_w[exp_n++] = 8'h7D;
        exp_w[exp_n++] = mem[i] ^ 8'h20;
      end else exp_w[exp_n++] = mem[i];
    end
    exp_w[exp_n++] = 8'h7F;
  endtask

  task automatic run_frame(int len, bit disturb);
    int got = 0;
    int tmo;
    bit done = 0;
    build_exp(len);
    @(negedge clk);
    msg_len = 8'(len);
    frame_req = 1'b1;
    @(negedge clk);
    frame_req = 1'b0;
    chk(frame_flag == 1'b1, "R2 flag set", int'(frame_flag), 1);
    while (!done) begin
      tmo = 0;
      while (!word_pend && tmo < 50) begin @(negedge clk); tmo++; end
      if (!word_pend) begin
        chk(0, "R10 word missing", got, exp_n);
        done = 1;
      end else begin
        logic [7:0] w = word_out;
        if (got < exp_n)
          chk(w == exp_w[got], (w == 8'h7D || got == 0) ? "R2/R5 word" : "R4/R5 word",
              int'(w), int'(exp_w[got]));
        else chk(0, "R10 extra word", int'(w), 0);
        if (got == 0) chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        if (disturb && got == 1) begin
          msg_len = 8'(len + 3);
          frame_req = 1'b1;
          @(negedge clk);
          frame_req = 1'b0;
        end
        if (w == 8'h7F && got == exp_n - 1) begin
          chk(frame_flag == 1'b0 && busy == 1'b0, "R6 flags cleared",
              int'({frame_flag, busy}), 0);
          done = 1;
        end
        begin
          logic [7:0] a = rd_addr;
          int d = int'($urandom_range(0, 3));
          for (int k = 0; k < d; k++) begin
            @(negedge clk);
            chk(word_pend && word_out == w, "R3 hold", int'(word_out), int'(w));
            chk(rd_addr == a, "R9 addr hold", int'(rd_addr), int'(a));
          end
        end
        word_take = 1'b1;
        @(negedge clk);
        word_take = 1'b0;
        got++;
      end
    end
    chk(got == exp_n, "R10 frame length", got, exp_n);
    chk(got >= len + 2 && got <= 2 * len + 2, "R10 bounds", got, len + 2);
    repeat (4) @(negedge clk);
    chk(!word_pend && !frame_flag, "R8 no extra frame",
        int'({word_pend, frame_flag}), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    chk(0, "watchdog", wd, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    chk(!word_pend && !frame_flag && !busy && rd_addr == 0, "R1 reset",
        int'({word_pend, frame_flag, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!word_pend && !frame_flag && rd_addr == 0, "R1 after release",
        int'({word_pend, frame_flag}), 0);
    run_frame(0, 0);                       // R7
    mem[0] = 8'h41;
    run_frame(1, 0);                       // R4
    mem[0] = 8'h7E; mem[1] = 8'h7F; mem[2] = 8'h7D; mem[3] = 8'h20;
    run_frame(4, 0);                       // R5 worst case 2m+2
    mem[4] = 8'h5E; mem[5] = 8'h00;
    run_frame(6, 1);                       // R8 disturbed
    for (int f = 0; f < 20; f++) begin
      int len = int'($urandom_range(0, 40));
      for (int i = 0; i < len; i++)
        mem[i] = ($urandom_range(0, 3) == 0) ?
                 8'(7'h7D + $urandom_range(0, 2)) : 8'($urandom);
      run_frame(len, f[0]);
    end
    for (int i = 0; i < 255; i++) mem[i] = 8'(i);
    run_frame(255, 0);                     // R4 R9 full address range
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule